// File: doc/BRIEF.md
# Authenticated Flash Region Address Mapper

This block sits between a host fetch port and an external-flash controller. It turns a logical byte address into the physical address of the 32-byte chunk that holds it. A small table of code regions drives the translation. Each region carries a protection mode: unprotected, encrypted only, or encrypted with authentication. In an authenticated region every 32 logical bytes occupy 36 physical bytes, because a 4-byte tag is kept after each chunk. The block reports that tag's physical address next to the chunk address, so a downstream cipher and tag checker can fetch both. The block does no cipher work and no tag checking.

The code regions are laid end to end in logical space, starting right after a reserved firmware area at the bottom of flash. Region 0 is always one unit (32 KiB logical) long. The other regions take a unit count from the configuration port, and a count of zero leaves a region unused. A data region follows the last code region and is always unprotected. A write-only configuration port loads the table, and a sticky lock freezes it. Each translation passes through one registered output stage with a valid/ready handshake.

Top module: `flash_region_mapper`

## Requirements
- R1: A logical address below RESERVED_BYTES (default 0x30000) gives out_err=1 with out_region, out_mode, out_chunk_addr and out_tag_addr all zero.
- R2: Code regions are contiguous in index order. Region 0 starts at logical and physical address RESERVED_BYTES. Each region's logical length is units×UNIT_BYTES, and a region with zero units takes no space.
- R3: In an authenticated region, out_chunk_addr = physical base + floor(offset/32)×36 and out_tag_addr = out_chunk_addr + 32. The region's physical length is units×UNIT_BYTES×36/32.
- R4: In unprotected and encrypt-only regions, out_chunk_addr = physical base + offset rounded down to 32 bytes, out_tag_addr = 0, and the physical length equals the logical length.
- R5: An address at or above the end of the last code region maps to the data region. There out_region = NUM_REGIONS and out_mode = 0, and the data region's physical base is the physical end of the code regions.
- R6: If the computed chunk address is at or above FLASH_BYTES (default 0x200000), the result is out_err=1 with all other result fields zero.
- R7: The mode encoding is 0 = unprotected, 1 = encrypt-only and 2 = authenticated. A configuration write with mode value 3 is ignored as a whole.
- R8: A configuration write with cfg_we=1 sets the mode and unit count of region cfg_idx. The unit count written to region 0 is ignored, because region 0 always has one unit. After reset every region is unprotected, regions 1 and up have zero units, and region 0 has one unit.
- R9: After a cycle with cfg_lock=1, every configuration write is ignored until reset.
- R10: in_ready = !out_valid || out_ready. An accepted address appears on the outputs one cycle later. While out_valid=1 and out_ready=0, all outputs hold steady.
- R11: During and right after reset, out_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region table write strobe |
| cfg_idx | input | $clog2(NUM_REGIONS) | Region being written |
| cfg_mode | input | 2 | Protection mode written |
| cfg_units | input | UNITS_W | Region length in 32 KiB units |
| cfg_lock | input | 1 | Sets the sticky table lock |
| in_valid | input | 1 | Fetch address valid |
| in_ready | output | 1 | Mapper can take an address |
| in_addr | input | ADDR_W | Logical byte address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_err | output | 1 | Access rejected |
| out_region | output | $clog2(NUM_REGIONS+1) | Region index, NUM_REGIONS for data |
| out_mode | output | 2 | Protection mode of the hit |
| out_chunk_addr | output | ADDR_W | Physical chunk address |
| out_tag_addr | output | ADDR_W | Physical tag address, 0 when no tag |

## Verification
The bench builds the block with its default parameters: four code regions, 32-byte chunks, 4-byte tags, 32 KiB units, a 192 KiB reserved area and 2 MiB of flash. With these values it can fill region 0 and region 1 as authenticated regions, make region 2 encrypt-only and leave region 3 empty. That puts the last chunk and tag of each authenticated region in reach, as well as the shifted physical base of the region after them and the data region's upper bound, where the 12 KiB of tag expansion pushes the physical result past the end of flash. The reset mapping, the ignored mode-3 write, the ignored region-0 length write, writes after the lock, and output stalls under backpressure are each tested directly.

// File: rtl/frm_pkg.sv
package frm_pkg;
   typedef enum logic [1:0] {
      MODE_PLAIN = 2'd0,
      MODE_ENC   = 2'd1,
      MODE_AUTH  = 2'd2,
      MODE_BAD   = 2'd3
   } prot_mode_e;
endpackage

// File: rtl/frm_region_table.sv
module frm_region_table
   import frm_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int UNITS_W     = 8,
   localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [IDX_W-1:0]                  cfg_idx,
   input  logic [1:0]                        cfg_mode,
   input  logic [UNITS_W-1:0]                cfg_units,
   input  logic                              cfg_lock,
   output logic [NUM_REGIONS-1:0][1:0]       tbl_mode,
   output logic [NUM_REGIONS-1:0][UNITS_W-1:0] tbl_units
);
   logic lock_q;
   logic wr_ok;

   assign wr_ok = cfg_we && !lock_q && (cfg_mode != MODE_BAD) &&
                  ({1'b0, cfg_idx} < (IDX_W+1)'(NUM_REGIONS));

   always_ff @(posedge clk) begin
      if (!rst_n) lock_q <= 1'b0;
      else if (cfg_lock) lock_q <= 1'b1;
   end

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) tbl_mode[g] <= MODE_PLAIN;
         else if (wr_ok && cfg_idx == IDX_W'(g)) tbl_mode[g] <= cfg_mode;
      end
      if (g == 0) begin : g_fixed
         assign tbl_units[g] = UNITS_W'(1);
      end else begin : g_sized
         always_ff @(posedge clk) begin
            if (!rst_n) tbl_units[g] <= '0;
            else if (wr_ok && cfg_idx == IDX_W'(g)) tbl_units[g] <= cfg_units;
         end
      end
   end

   // R9: lock is sticky and freezes the table
   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
   assert_lock_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(tbl_mode) && $stable(tbl_units)));
   // R7: a bad mode never lands in the table
   assert_no_bad_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_mode == MODE_BAD |=> $stable(tbl_mode));
endmodule

// File: rtl/frm_layout.sv
module frm_layout
   import frm_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int UNITS_W     = 8,
   parameter int PW          = 34,
   parameter longint UNIT_BYTES  = 32768,
   parameter longint CHUNK_BYTES = 32,
   parameter longint TAG_BYTES   = 4,
   parameter longint RSVD_BYTES  = 196608
) (
   input  logic [NUM_REGIONS-1:0][1:0]         tbl_mode,
   input  logic [NUM_REGIONS-1:0][UNITS_W-1:0] tbl_units,
   output logic [NUM_REGIONS-1:0][PW-1:0]      lbase,
   output logic [NUM_REGIONS-1:0][PW-1:0]      lsize,
   output logic [NUM_REGIONS-1:0][PW-1:0]      pbase,
   output logic [PW-1:0]                       data_lbase,
   output logic [PW-1:0]                       data_pbase
);
   localparam logic [PW-1:0] UNIT_L = PW'(UNIT_BYTES);
   localparam logic [PW-1:0] UNIT_P = PW'(UNIT_BYTES * (CHUNK_BYTES + TAG_BYTES) / CHUNK_BYTES);
   localparam logic [PW-1:0] RSVD_L = PW'(RSVD_BYTES);

   logic [PW-1:0] lacc [NUM_REGIONS+1];
   logic [PW-1:0] pacc [NUM_REGIONS+1];
   logic [NUM_REGIONS-1:0][PW-1:0] psize;

   assign lacc[0] = RSVD_L;
   assign pacc[0] = RSVD_L;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sum
      assign lsize[g] = PW'(tbl_units[g]) * UNIT_L;
      assign psize[g] = (tbl_mode[g] == MODE_AUTH) ? PW'(tbl_units[g]) * UNIT_P : lsize[g];
      assign lbase[g] = lacc[g];
      assign pbase[g] = pacc[g];
      assign lacc[g+1] = lacc[g] + lsize[g];
      assign pacc[g+1] = pacc[g] + psize[g];
   end

   assign data_lbase = lacc[NUM_REGIONS];
   assign data_pbase = pacc[NUM_REGIONS];
endmodule

// File: rtl/frm_xlate.sv
module frm_xlate
   import frm_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int UNITS_W     = 8,
   parameter int ADDR_W      = 32,
   parameter int PW          = 34,
   parameter longint CHUNK_BYTES = 32,
   parameter longint TAG_BYTES   = 4,
   parameter longint RSVD_BYTES  = 196608,
   parameter longint FLASH_BYTES = 2097152,
   localparam int RID_W = $clog2(NUM_REGIONS+1)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [ADDR_W-1:0]                   addr,
   input  logic [NUM_REGIONS-1:0][1:0]         tbl_mode,
   input  logic [NUM_REGIONS-1:0][UNITS_W-1:0] tbl_units,
   input  logic [NUM_REGIONS-1:0][PW-1:0]      lbase,
   input  logic [NUM_REGIONS-1:0][PW-1:0]      lsize,
   input  logic [NUM_REGIONS-1:0][PW-1:0]      pbase,
   input  logic [PW-1:0]                       data_lbase,
   input  logic [PW-1:0]                       data_pbase,
   output logic                                x_err,
   output logic [RID_W-1:0]                    x_region,
   output logic [1:0]                          x_mode,
   output logic [ADDR_W-1:0]                   x_chunk,
   output logic [ADDR_W-1:0]                   x_tag
);
   localparam int CH_LG = $clog2(CHUNK_BYTES);
   localparam logic [PW-1:0] STRIDE = PW'(CHUNK_BYTES + TAG_BYTES);
   localparam logic [PW-1:0] CHUNK_L = PW'(CHUNK_BYTES);
   localparam logic [PW-1:0] RSVD_L = PW'(RSVD_BYTES);
   localparam logic [PW-1:0] FLASH_L = PW'(FLASH_BYTES);

   logic [PW-1:0] addr_x;
   logic [NUM_REGIONS-1:0] hit;
   logic [PW-1:0] sel_lbase, sel_pbase, off, cidx, phys;
   logic [1:0] sel_mode;
   logic [RID_W-1:0] sel_idx;
   logic below, over;

   assign addr_x = PW'(addr);

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
      assign hit[g] = (tbl_units[g] != '0) && (addr_x >= lbase[g]) &&
                      (addr_x < lbase[g] + lsize[g]);
   end

   always_comb begin
      sel_lbase = data_lbase;
      sel_pbase = data_pbase;
      sel_mode  = MODE_PLAIN;
      sel_idx   = RID_W'(NUM_REGIONS);
      for (int i = NUM_REGIONS-1; i >= 0; i--) begin
         if (hit[i]) begin
            sel_lbase = lbase[i];
            sel_pbase = pbase[i];
            sel_mode  = tbl_mode[i];
            sel_idx   = RID_W'(i);
         end
      end
      off  = addr_x - sel_lbase;
      cidx = off >> CH_LG;
      if (sel_mode == MODE_AUTH) phys = sel_pbase + cidx * STRIDE;
      else                       phys = sel_pbase + (cidx << CH_LG);
      below = addr_x < RSVD_L;
      over  = phys >= FLASH_L;
      x_err = below || over;
      if (x_err) begin
         x_region = '0;
         x_mode   = MODE_PLAIN;
         x_chunk  = '0;
         x_tag    = '0;
      end else begin
         x_region = sel_idx;
         x_mode   = sel_mode;
         x_chunk  = ADDR_W'(phys);
         x_tag    = (sel_mode == MODE_AUTH) ? ADDR_W'(phys + CHUNK_L) : '0;
      end
   end

   // R2: code regions never overlap
   assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
   // R3: authenticated chunks sit on the 36-byte physical grid of their region
   assert_auth_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!x_err && sel_mode == MODE_AUTH) |-> (((phys - sel_pbase) % STRIDE) == '0));
   // R6: no accepted chunk starts past the flash end
   assert_in_flash_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !x_err |-> (PW'(x_chunk) < FLASH_L));
endmodule

// File: rtl/flash_region_mapper.sv
module flash_region_mapper
   import frm_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGIONS = 4,
   parameter int UNITS_W     = 8,
   parameter longint CHUNK_BYTES = 32,
   parameter longint TAG_BYTES   = 4,
   parameter longint UNIT_BYTES  = 32768,
   parameter longint RSVD_BYTES  = 196608,
   parameter longint FLASH_BYTES = 2097152,
   localparam int IDX_W = $clog2(NUM_REGIONS),
   localparam int RID_W = $clog2(NUM_REGIONS+1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [1:0]         cfg_mode,
   input  logic [UNITS_W-1:0] cfg_units,
   input  logic               cfg_lock,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [ADDR_W-1:0]  in_addr,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               out_err,
   output logic [RID_W-1:0]   out_region,
   output logic [1:0]         out_mode,
   output logic [ADDR_W-1:0]  out_chunk_addr,
   output logic [ADDR_W-1:0]  out_tag_addr
);
   localparam int PW = ADDR_W + 2;

   if (NUM_REGIONS < 2) begin : g_bad_nreg
      $error("NUM_REGIONS must be at least 2");
   end
   if ((CHUNK_BYTES & (CHUNK_BYTES - 1)) != 0) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a power of two");
   end
   if ((UNIT_BYTES % CHUNK_BYTES) != 0) begin : g_bad_unit
      $error("UNIT_BYTES must be a multiple of CHUNK_BYTES");
   end
   if (RSVD_BYTES >= FLASH_BYTES || FLASH_BYTES > (64'd1 << ADDR_W)) begin : g_bad_flash
      $error("reserved area and flash size do not fit the address width");
   end
   if (RSVD_BYTES + NUM_REGIONS * ((64'd1 << UNITS_W) - 1) * UNIT_BYTES *
       (CHUNK_BYTES + TAG_BYTES) / CHUNK_BYTES >= (64'd1 << PW)) begin : g_bad_span
      $error("largest region layout overflows the internal width");
   end

   logic [NUM_REGIONS-1:0][1:0]         tbl_mode;
   logic [NUM_REGIONS-1:0][UNITS_W-1:0] tbl_units;
   logic [NUM_REGIONS-1:0][PW-1:0]      lbase, lsize, pbase;
   logic [PW-1:0] data_lbase, data_pbase;
   logic x_err;
   logic [RID_W-1:0] x_region;
   logic [1:0] x_mode;
   logic [ADDR_W-1:0] x_chunk, x_tag;

   frm_region_table #(.NUM_REGIONS(NUM_REGIONS), .UNITS_W(UNITS_W)) table_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_mode(cfg_mode), .cfg_units(cfg_units), .cfg_lock(cfg_lock),
      .tbl_mode(tbl_mode), .tbl_units(tbl_units));

   frm_layout #(.NUM_REGIONS(NUM_REGIONS), .UNITS_W(UNITS_W), .PW(PW),
      .UNIT_BYTES(UNIT_BYTES), .CHUNK_BYTES(CHUNK_BYTES), .TAG_BYTES(TAG_BYTES),
      .RSVD_BYTES(RSVD_BYTES)) layout_i (
      .tbl_mode(tbl_mode), .tbl_units(tbl_units), .lbase(lbase), .lsize(lsize),
      .pbase(pbase), .data_lbase(data_lbase), .data_pbase(data_pbase));

   frm_xlate #(.NUM_REGIONS(NUM_REGIONS), .UNITS_W(UNITS_W), .ADDR_W(ADDR_W),
      .PW(PW), .CHUNK_BYTES(CHUNK_BYTES), .TAG_BYTES(TAG_BYTES),
      .RSVD_BYTES(RSVD_BYTES), .FLASH_BYTES(FLASH_BYTES)) xlate_i (
      .clk(clk), .rst_n(rst_n), .addr(in_addr), .tbl_mode(tbl_mode),
      .tbl_units(tbl_units), .lbase(lbase), .lsize(lsize), .pbase(pbase),
      .data_lbase(data_lbase), .data_pbase(data_pbase), .x_err(x_err),
      .x_region(x_region), .x_mode(x_mode), .x_chunk(x_chunk), .x_tag(x_tag));

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_err        <= 1'b0;
         out_region     <= '0;
         out_mode       <= MODE_PLAIN;
         out_chunk_addr <= '0;
         out_tag_addr   <= '0;
      end else if (in_valid && in_ready) begin
         out_valid      <= 1'b1;
         out_err        <= x_err;
         out_region     <= x_region;
         out_mode       <= x_mode;
         out_chunk_addr <= x_chunk;
         out_tag_addr   <= x_tag;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R10: a stalled result holds
   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_chunk_addr) &&
      $stable(out_tag_addr) && $stable(out_region) && $stable(out_err)));
   // R1: reserved addresses come back rejected
   assert_reserved_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (PW'(in_addr) < PW'(RSVD_BYTES))) |=> (out_valid && out_err));
   // R3: the tag slot follows its chunk
   assert_tag_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err && out_mode == MODE_AUTH) |->
      (out_tag_addr == out_chunk_addr + ADDR_W'(CHUNK_BYTES)));
endmodule

// File: tb/flash_region_mapper_tb_top.sv
module flash_region_mapper_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int NV = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_idx = '0;
   logic [1:0] cfg_mode = '0;
   logic [7:0] cfg_units = '0;
   logic cfg_lock = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [31:0] in_addr = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic out_err;
   logic [2:0] out_region;
   logic [1:0] out_mode;
   logic [31:0] out_chunk_addr, out_tag_addr;

   int n_chk = 0;
   int n_bad = 0;
   string vreq [NV];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_region_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_mode(cfg_mode), .cfg_units(cfg_units), .cfg_lock(cfg_lock),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
      .out_region(out_region), .out_mode(out_mode),
      .out_chunk_addr(out_chunk_addr), .out_tag_addr(out_tag_addr));

   // {addr, err, region, mode, chunk, tag}
   localparam logic [101:0] VEC [NV] = '{
      {32'h0000_0000, 1'b1, 3'd0, 2'd0, 32'h0, 32'h0},
      {32'h0002_FFFF, 1'b1, 3'd0, 2'd0, 32'h0, 32'h0},
      {32'h0003_0000, 1'b0, 3'd0, 2'd2, 32'h0003_0000, 32'h0003_0020},
      {32'h0003_0025, 1'b0, 3'd0, 2'd2, 32'h0003_0024, 32'h0003_0044},
      {32'h0003_7FFF, 1'b0, 3'd0, 2'd2, 32'h0003_8FDC, 32'h0003_8FFC},
      {32'h0003_8000, 1'b0, 3'd1, 2'd2, 32'h0003_9000, 32'h0003_9020},
      {32'h0004_7FE0, 1'b0, 3'd1, 2'd2, 32'h0004_AFDC, 32'h0004_AFFC},
      {32'h0004_8000, 1'b0, 3'd2, 2'd1, 32'h0004_B000, 32'h0},
      {32'h0004_803F, 1'b0, 3'd2, 2'd1, 32'h0004_B020, 32'h0},
      {32'h0005_0000, 1'b0, 3'd4, 2'd0, 32'h0005_3000, 32'h0},
      {32'h0006_0010, 1'b0, 3'd4, 2'd0, 32'h0006_3000, 32'h0},
      {32'h001F_CFFF, 1'b0, 3'd4, 2'd0, 32'h001F_FFE0, 32'h0},
      {32'h001F_D000, 1'b1, 3'd0, 2'd0, 32'h0, 32'h0},
      {32'hFFFF_FFFF, 1'b1, 3'd0, 2'd0, 32'h0, 32'h0}
   };

   task automatic check(input string req, input logic [69:0] act, input logic [69:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] idx, input logic [1:0] mode, input logic [7:0] units);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_mode = mode; cfg_units = units;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic xfer(input logic [31:0] a);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [69:0] result();
      return {out_valid, out_err, out_region, out_mode, out_chunk_addr, out_tag_addr};
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      vreq = '{"R1", "R1", "R3", "R3", "R3", "R2 R7 R8", "R3", "R4 R9", "R4",
               "R5", "R5", "R5 R6", "R6", "R6"};
      repeat (3) @(negedge clk);
      // R11: idle after reset
      check("R11", {68'd0, out_valid, in_ready}, {68'd0, 1'b0, 1'b1});
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", {68'd0, out_valid, in_ready}, {68'd0, 1'b0, 1'b1});

      // R8: reset table, region 0 plain one unit
      xfer(32'h0003_0040);
      check("R8", result(), {1'b1, 1'b0, 3'd0, 2'd0, 32'h0003_0040, 32'h0});
      xfer(32'h0003_8000);
      check("R5", result(), {1'b1, 1'b0, 3'd4, 2'd0, 32'h0003_8000, 32'h0});

      cfg_write(2'd0, 2'd2, 8'd7);   // units ignored for region 0 (R8)
      cfg_write(2'd1, 2'd2, 8'd2);
      cfg_write(2'd2, 2'd1, 8'd1);
      cfg_write(2'd1, 2'd3, 8'd9);   // mode 3 ignored (R7)
      @(negedge clk); cfg_lock = 1'b1;
      @(negedge clk); cfg_lock = 1'b0;
      cfg_write(2'd2, 2'd2, 8'd5);   // after lock, ignored (R9)

      for (int i = 0; i < NV; i++) begin
         xfer(VEC[i][101:70]);
         check(vreq[i], result(), {1'b1, VEC[i][69:0]});
      end

      // R10: backpressure
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h0003_0000;
      @(negedge clk);
      check("R10", {69'd0, in_ready}, {69'd0, 1'b0});
      in_addr = 32'h0004_8000;
      @(negedge clk);
      check("R10", result(), {1'b1, 1'b0, 3'd0, 2'd2, 32'h0003_0000, 32'h0003_0020});
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10", result(), {1'b1, 1'b0, 3'd2, 2'd1, 32'h0004_B000, 32'h0});
      @(negedge clk);
      check("R10", {69'd0, out_valid}, {69'd0, 1'b0});

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule